// File: doc/BRIEF.md
# Pipelined CORDIC Sine and Cosine Generator

This block turns an unsigned phase word into a pair of signed samples: the sine and the cosine of that phase. The phase spans the whole circle across its full binary range, so a value of 2^PHASE_W would be 360 degrees. An accumulator that overflows therefore wraps the angle correctly without extra logic. The samples are computed by rotation-mode CORDIC. Each micro-rotation uses only shifts, additions and subtractions, and a small arctangent table that the design computes at elaboration time. No multiplier is used.

The first register folds the phase into one of four quadrants. It pre-rotates a start vector whose length is the reciprocal of the CORDIC gain, so the remaining angle lies within plus or minus 45 degrees and the results need no scaling afterwards. After that register come STAGES micro-rotation registers and one register that rounds and saturates the result. Each clock accepts a new angle. A valid flag travels with each sample, and the output registers keep their last values when no new sample leaves the pipeline.

Top module: `cordic_sincos`

## Requirements
- R1: Reset clears every in-flight valid flag and sets both outputs to 0. No outValid pulse appears after reset until a new input is presented.
- R2: outValid rises exactly STAGES+2 clock edges after the edge that sampled inValid. Inputs on consecutive clocks give outputs on consecutive clocks. Every accepted phase produces exactly one output, in the order of the inputs.
- R3: For phase 0, cosOut is within 2 LSB of +32767 and sinOut is within 2 LSB of 0.
- R4: For phases 2^22, 2^23 and 3*2^22 (90, 180 and 270 degrees), both outputs are within 2 LSB of the exact values (0 or ±32767).
- R5: For any phase p, sinOut and cosOut are within 3 LSB of round(32767*sin(2*pi*p/2^24)) and round(32767*cos(2*pi*p/2^24)).
- R6: Phases just below 2^24 wrap to just above 0. Phases on either side of a 45-degree fold boundary (2^21 ± 1 and similar) meet the R5 accuracy.
- R7: While outValid is low, sinOut and cosOut keep the values of the last output sample.
- R8: The outputs saturate symmetrically to ±32767. The code -32768 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register samples on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Marks phaseIn as a new angle for this cycle |
| phaseIn | input | PHASE_W (24) | Unsigned phase; the full word range covers one turn |
| outValid | output | 1 | Marks sinOut and cosOut as a fresh sample |
| sinOut | output | OUT_W (16) | Signed two's-complement sine, full scale 32767 |
| cosOut | output | OUT_W (16) | Signed two's-complement cosine, full scale 32767 |

## Verification
The bench builds the block at its default parameters: a 24-bit phase, 16-bit outputs, 18 rotation stages, 2 guard bits and 5 fractional bits. The 18 stages bring the residual angle error down to a fraction of an output LSB. This lets the four axis angles be held to a 2-LSB window, and random phases of every quadrant to a 3-LSB window, against a real-valued reference. The latency of 20 clocks is long enough that back-to-back bursts, sparse random issue and a reset that lands on a full pipeline all leave many samples in flight at once. This exercises ordering, throughput and the flushing of valid flags.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic capture;  // load the quadrant-fold register
    logic emit;     // load the rounded output register
  } cordStrobeT;

  localparam real PI = 3.14159265358979323846;

  // Arctangent of 2^-idx, expressed in phase units of a phaseW-bit turn.
  function automatic int atanPhase(input int idx, input int phaseW);
    real a;
    a = $atan(2.0 ** (-idx)) / (2.0 * PI) * (2.0 ** phaseW);
    return $rtoi(a + 0.5);
  endfunction

  // Reciprocal of the accumulated CORDIC gain over n micro-rotations.
  function automatic real invGain(input int n);
    real k;
    k = 1.0;
    for (int i = 0; i < n; i++) k = k / $sqrt(1.0 + 2.0 ** (-2 * i));
    return k;
  endfunction

endpackage

// File: rtl/cordic_stage.sv
module cordic_stage #(
  parameter int IW      = 23,
  parameter int ZW      = 24,
  parameter int PHASE_W = 24,
  parameter int IDX     = 0
) (
  input  logic                 clk,
  input  logic signed [IW-1:0] xIn,
  input  logic signed [IW-1:0] yIn,
  input  logic signed [ZW-1:0] zIn,
  output logic signed [IW-1:0] xOut,
  output logic signed [IW-1:0] yOut,
  output logic signed [ZW-1:0] zOut
);
  import cordic_pkg::*;

  localparam logic signed [ZW-1:0] ANG = ZW'(atanPhase(IDX, PHASE_W));

  logic signed [IW-1:0] xSh;
  logic signed [IW-1:0] ySh;

  always_comb begin
    xSh = xIn >>> IDX;
    ySh = yIn >>> IDX;
  end

  // Rotate toward zero residual: positive when residual is non-negative.
  always_ff @(posedge clk) begin
    if (!zIn[ZW-1]) begin
      xOut <= xIn - ySh;
      yOut <= yIn + xSh;
      zOut <= zIn - ANG;
    end else begin
      xOut <= xIn + ySh;
      yOut <= yIn - xSh;
      zOut <= zIn + ANG;
    end
  end

endmodule

// File: rtl/cordic_ctrl.sv
module cordic_ctrl #(
  parameter int STAGES = 18
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   inValid,
  output cordic_pkg::cordStrobeT strobe,
  output logic                   outValid
);
  localparam int LAT = STAGES + 2;
  localparam int PW  = $clog2(LAT + 2) + 1;

  logic [LAT-1:0] vld;

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[LAT-2:0], inValid};
  end

  always_comb begin
    strobe.capture = inValid;
    strobe.emit    = vld[LAT-2];
    outValid       = vld[LAT-1];
  end

  // Checker state: samples accepted but not yet delivered.
  logic [PW-1:0] pend;
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= pend + PW'(inValid) - PW'(outValid);
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> !outValid)
    else $error("valid survived reset");

  // R2
  pend_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pend <= PW'(LAT))
    else $error("more samples in flight than pipeline depth");

  // R2
  no_orphan_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> pend != '0)
    else $error("output without a matching input");

endmodule

// File: rtl/cordic_datapath.sv
module cordic_datapath #(
  parameter int PHASE_W = 24,
  parameter int OUT_W   = 16,
  parameter int STAGES  = 18,
  parameter int GUARD   = 2,
  parameter int FRAC    = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  cordic_pkg::cordStrobeT  strobe,
  input  logic [PHASE_W-1:0]      phaseIn,
  output logic signed [OUT_W-1:0] sinOut,
  output logic signed [OUT_W-1:0] cosOut
);
  import cordic_pkg::*;

  localparam int IW = OUT_W + GUARD + FRAC;
  localparam int ZW = PHASE_W;
  localparam real FULL = real'((1 << (OUT_W - 1)) - 1);
  localparam int XINIT = $rtoi(invGain(STAGES) * FULL * (2.0 ** FRAC) + 0.5);
  localparam logic signed [IW-1:0] XI    = IW'(XINIT);
  localparam logic signed [IW-1:0] RHALF = IW'(1 << (FRAC - 1));
  localparam logic signed [IW-1:0] MAXV  = IW'((1 << (OUT_W - 1)) - 1);
  localparam logic [PHASE_W-1:0] QOFF    = PHASE_W'(1) << (PHASE_W - 3);
  localparam logic signed [ZW-1:0] FOLDLIM = ZW'(1) <<< (PHASE_W - 3);
  localparam int RESLIM = 2 * atanPhase(STAGES - 1, PHASE_W) + STAGES;

  // Quadrant fold.
  logic [1:0]           quad;
  logic [PHASE_W-1:0]   resid;
  logic signed [IW-1:0] xF, yF;
  logic signed [ZW-1:0] zF;

  always_comb begin
    quad  = 2'((phaseIn + QOFF) >> (PHASE_W - 2));
    resid = phaseIn - {quad, {(PHASE_W - 2){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      zF <= signed'(resid);
      unique case (quad)
        2'd0: begin xF <= XI;  yF <= '0;  end
        2'd1: begin xF <= '0;  yF <= XI;  end
        2'd2: begin xF <= -XI; yF <= '0;  end
        default: begin xF <= '0; yF <= -XI; end
      endcase
    end
  end

  // Micro-rotation chain.
  logic signed [IW-1:0] xs [STAGES];
  logic signed [IW-1:0] ys [STAGES];
  logic signed [ZW-1:0] zs [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_rot
    if (i == 0) begin : g_first
      cordic_stage #(.IW(IW), .ZW(ZW), .PHASE_W(PHASE_W), .IDX(i)) u_stage (
        .clk(clk), .xIn(xF), .yIn(yF), .zIn(zF),
        .xOut(xs[i]), .yOut(ys[i]), .zOut(zs[i]));
    end else begin : g_next
      cordic_stage #(.IW(IW), .ZW(ZW), .PHASE_W(PHASE_W), .IDX(i)) u_stage (
        .clk(clk), .xIn(xs[i-1]), .yIn(ys[i-1]), .zIn(zs[i-1]),
        .xOut(xs[i]), .yOut(ys[i]), .zOut(zs[i]));
    end
  end

  // Round to nearest, then clamp symmetrically.
  function automatic logic signed [OUT_W-1:0] rndSat(input logic signed [IW-1:0] v);
    logic signed [IW-1:0] s;
    s = (v + RHALF) >>> FRAC;
    if (s > MAXV)       s = MAXV;
    else if (s < -MAXV) s = -MAXV;
    return OUT_W'(s);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      sinOut <= '0;
      cosOut <= '0;
    end else if (strobe.emit) begin
      sinOut <= rndSat(ys[STAGES-1]);
      cosOut <= rndSat(xs[STAGES-1]);
    end
  end

  // R5
  fold_range_chk: assert property (@(posedge clk) disable iff (rst)
    $past(strobe.capture) |-> (zF >= -FOLDLIM && zF < FOLDLIM))
    else $error("folded residual outside +-45 degrees");

  // R5
  resid_conv_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.emit |-> (zs[STAGES-1] <= ZW'(RESLIM) && zs[STAGES-1] >= -ZW'(RESLIM)))
    else $error("residual angle did not converge");

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.emit |=> ($stable(sinOut) && $stable(cosOut)))
    else $error("output changed without a sample");

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    sinOut != {1'b1, {(OUT_W - 1){1'b0}}} && cosOut != {1'b1, {(OUT_W - 1){1'b0}}})
    else $error("asymmetric negative code produced");

endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos #(
  parameter int PHASE_W = 24,
  parameter int OUT_W   = 16,
  parameter int STAGES  = 18,
  parameter int GUARD   = 2,
  parameter int FRAC    = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic [PHASE_W-1:0]      phaseIn,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] sinOut,
  output logic signed [OUT_W-1:0] cosOut
);
  cordic_pkg::cordStrobeT strobe;

  cordic_ctrl #(.STAGES(STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid),
    .strobe(strobe), .outValid(outValid));

  cordic_datapath #(
    .PHASE_W(PHASE_W), .OUT_W(OUT_W), .STAGES(STAGES),
    .GUARD(GUARD), .FRAC(FRAC)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .phaseIn(phaseIn),
    .sinOut(sinOut), .cosOut(cosOut));

endmodule

// File: tb/tb_cordic_sincos.sv
module tb_cordic_sincos;
  localparam int PHASE_W = 24;
  localparam int OUT_W   = 16;
  localparam int STAGES  = 18;
  localparam int LAT     = STAGES + 2;
  localparam real TWO_PI = 6.28318530717958647692;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [PHASE_W-1:0] phaseIn = '0;
  logic outValid;
  logic signed [OUT_W-1:0] sinOut, cosOut;

  cordic_sincos #(.PHASE_W(PHASE_W), .OUT_W(OUT_W), .STAGES(STAGES)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .phaseIn(phaseIn),
    .outValid(outValid), .sinOut(sinOut), .cosOut(cosOut));

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  bit rstTest = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard entries.
  int    qPhase[$];
  int    qCyc[$];
  int    qTol[$];
  string qTag[$];
  int lastSin = 0;
  int lastCos = 0;

  function automatic int refVal(input int phase, input bit isSin);
    real a, v;
    a = real'(phase) / (2.0 ** PHASE_W) * TWO_PI;
    v = 32767.0 * (isSin ? $sin(a) : $cos(a));
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Output monitor, sampled away from the rising edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (outValid) begin
        if (qPhase.size() == 0) begin
          check(1'b0, rstTest ? "R1" : "R2", "unexpected outValid", 1, 0);
        end else begin
          int ph, ic, tol, es, ec;
          string tg;
          ph = qPhase.pop_front(); ic = qCyc.pop_front();
          tol = qTol.pop_front();  tg = qTag.pop_front();
          es = refVal(ph, 1'b1);   ec = refVal(ph, 1'b0);
          check(cyc - ic == LAT, "R2", "latency", cyc - ic, LAT);
          check((int'(sinOut) - es <= tol) && (es - int'(sinOut) <= tol),
                tg, $sformatf("sin phase=%0d", ph), int'(sinOut), es);
          check((int'(cosOut) - ec <= tol) && (ec - int'(cosOut) <= tol),
                tg, $sformatf("cos phase=%0d", ph), int'(cosOut), ec);
          check(int'(sinOut) >= -32767 && int'(cosOut) >= -32767, "R8",
                "saturation floor", (int'(sinOut) < int'(cosOut)) ? int'(sinOut) : int'(cosOut), -32767);
          lastSin = int'(sinOut);
          lastCos = int'(cosOut);
        end
      end else begin
        check(int'(sinOut) == lastSin, "R7", "sin hold", int'(sinOut), lastSin);
        check(int'(cosOut) == lastCos, "R7", "cos hold", int'(cosOut), lastCos);
      end
    end
  end

  task automatic issue(input int phase, input int tol, input string tag);
    inValid = 1'b1;
    phaseIn = PHASE_W'(phase);
    qPhase.push_back(phase); qCyc.push_back(cyc);
    qTol.push_back(tol);     qTag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Watchdog.
  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finishRun();
  end

  initial begin
    int r;
    r = $urandom(32'h5eed_c0de);
    repeat (5) @(negedge clk);
    // R1: reset state
    check(outValid == 1'b0, "R1", "outValid in reset", int'(outValid), 0);
    check(sinOut == 0 && cosOut == 0, "R1", "outputs in reset", int'(sinOut) | int'(cosOut), 0);
    rst = 1'b0;
    idle(3);
    check(outValid == 1'b0, "R1", "outValid idle after reset", int'(outValid), 0);

    // Directed corners, back to back (R2 throughput).
    issue(0, 2, "R3");
    issue(1 << 22, 2, "R4");
    issue(1 << 23, 2, "R4");
    issue(3 << 22, 2, "R4");
    issue((1 << 24) - 1, 3, "R6");
    issue(1, 3, "R6");
    issue((1 << 21) - 1, 3, "R6");
    issue(1 << 21, 3, "R6");
    issue((1 << 21) + 1, 3, "R6");
    issue((7 << 21) - 1, 3, "R6");
    issue(7 << 21, 3, "R6");
    issue((1 << 24) - (1 << 21), 3, "R6");
    idle(LAT + 4);

    // Constrained random: any phase, about 60 percent issue rate.
    for (int i = 0; i < 800; i++) begin
      if ($urandom_range(9) < 6) issue(int'($urandom() & 32'h00FF_FFFF), 3, "R5");
      else idle(1);
    end
    // Random phases in one-LSB clusters around quadrant boundaries.
    for (int i = 0; i < 40; i++) begin
      int b;
      b = int'($urandom_range(7)) << 21;
      issue((b + int'($urandom_range(4)) - 2) & 32'h00FF_FFFF, 3, "R6");
    end
    idle(LAT + 4);
    check(qPhase.size() == 0, "R2", "all samples delivered", qPhase.size(), 0);

    // Reset with a full pipeline: nothing may come out afterwards (R1).
    for (int i = 0; i < LAT; i++) issue(int'($urandom() & 32'h00FF_FFFF), 3, "R5");
    idle(LAT / 2);
    rstTest = 1'b1;
    rst = 1'b1;
    qPhase.delete(); qCyc.delete(); qTol.delete(); qTag.delete();
    idle(3);
    rst = 1'b0;
    lastSin = 0; lastCos = 0;
    @(negedge clk);
    check(sinOut == 0 && cosOut == 0, "R1", "outputs cleared by reset", int'(sinOut) | int'(cosOut), 0);
    idle(LAT + 3);
    rstTest = 1'b0;

    // Post-reset sanity: block still works.
    issue(0, 2, "R3");
    issue(1 << 22, 2, "R4");
    idle(LAT + 4);
    check(qPhase.size() == 0, "R2", "post-reset samples delivered", qPhase.size(), 0);
    finishRun();
  end

endmodule